// File: doc/BRIEF.md
# Two-Level Interrupt Router with GPIO Edge Capture

This block gathers every interrupt source of a small system and turns them into two request lines for the processor core: a fast request and a normal request. The fast request has the higher priority and may pre-empt a handler that is already running on the normal request. Each source is steered to one of the two lines by a per-source steering bit, and gated by a per-source enable mask. A third output, the wake line, is the OR of all pending and enabled sources whatever their steering. The power controller uses it to leave the low-power idle state.

Status is kept in two levels. The first-level pending register tells software which source is interrupting. Bit 0 is the general-purpose I/O bank, and bits 1 and up are the level-sensitive module lines. The second level for the I/O bank is a per-pin edge-status register. Each of the 28 pins passes through a two-flop synchroniser and can be armed to capture a rising edge, a falling edge, or both. Captured edges stay set until software writes a one to clear them. Software can also read the synchronised pin values directly, and it drives an output value and an output-enable for each pin.

The register port is a single-cycle write port with a combinational read path.

Top module: `intc_top`

## Requirements
- R1: After reset, every writable register and the edge-status register read as zero, `gpio_oe` and `gpio_out` are zero, and `fiq_req`, `irq_req` and `wake_req` are low.
- R2: A 0-to-1 transition on pin n sets edge-status bit n (address 8) only while rise-enable bit n (address 6) is one. Other pins and disabled pins leave their bits untouched.
- R3: A 1-to-0 transition on pin n sets edge-status bit n only while fall-enable bit n (address 7) is one. A rising transition on a fall-only pin sets nothing.
- R4: With both enable bits set for a pin, either transition sets its edge-status bit.
- R5: Edge-status bits are sticky. Writing a one to bit n at address 8 clears it, and writing zeros changes nothing.
- R6: The pending register (address 0, read-only) has bit 0 equal to the OR of all edge-status bits. Bit k+1 equals module line `mod_irq[k]`.
- R7: `fiq_req` is high exactly when some pending source has its mask bit (address 1) set and its steering bit (address 2) equal to one. `irq_req` is high exactly when such a source has its steering bit equal to zero.
- R8: A pending source whose mask bit is zero drives neither request line nor `wake_req`.
- R9: `wake_req` is high whenever any pending source is unmasked, independent of its steering bit.
- R10: Address 3 reads the pin inputs after the two-flop synchroniser. A pin change driven before clock edge k is visible there after edge k+1. Addresses 4 and 5 are read/write and drive `gpio_out` and `gpio_oe`.
- R11: An edge on a pin changed before clock edge k sets its edge-status bit at edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0 pending, 1 mask, 2 steer, 3 pin, 4 out, 5 dir, 6 rise, 7 fall, 8 edge status) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| gpio_in | input | NGPIO (28) | Asynchronous pin inputs |
| gpio_out | output | NGPIO (28) | Pin output values |
| gpio_oe | output | NGPIO (28) | Pin output enables |
| mod_irq | input | NMOD (8) | Level-sensitive module interrupt lines |
| fiq_req | output | 1 | Fast interrupt request |
| irq_req | output | 1 | Normal interrupt request |
| wake_req | output | 1 | Enabled-interrupt wake condition |

## Verification
The bench builds the block with its default parameters: 28 pins and 8 module lines, which gives a 9-bit pending vector. This makes the highest pin (27) and the highest pending bit (8) reachable, so the edges of the packed fields are exercised as well as the low bits. The synchroniser latency is probed cycle by cycle, both on the direct pin read and on edge capture.

// File: rtl/ic_pkg.sv
package ic_pkg;

    typedef enum logic [3:0] {
        SEL_PEND  = 4'd0,
        SEL_MASK  = 4'd1,
        SEL_STEER = 4'd2,
        SEL_PIN   = 4'd3,
        SEL_DOUT  = 4'd4,
        SEL_DIR   = 4'd5,
        SEL_RISE  = 4'd6,
        SEL_FALL  = 4'd7,
        SEL_EDGE  = 4'd8
    } reg_sel_e;

    typedef struct packed {
        logic fiq;
        logic irq;
        logic wake;
    } req_t;

    function automatic logic hit(input logic we, input logic [3:0] addr, input reg_sel_e sel);
        return we && (addr == sel);
    endfunction

endpackage

// File: rtl/ic_gpio_edge.sv
module ic_gpio_edge #(
    parameter int NGPIO = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NGPIO-1:0] pin_async,
    input  logic [NGPIO-1:0] rise_en,
    input  logic [NGPIO-1:0] fall_en,
    input  logic             clr_strobe,
    input  logic [NGPIO-1:0] clr_bits,
    output logic [NGPIO-1:0] pin_sync,
    output logic [NGPIO-1:0] edge_st
);
    logic [NGPIO-1:0] meta_q;
    logic [NGPIO-1:0] sync_q;
    logic [NGPIO-1:0] prev_q;
    logic [NGPIO-1:0] event_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < NGPIO; i++) begin : g_pin
        logic rose_w;
        logic fell_w;
        assign rose_w     = sync_q[i] & ~prev_q[i];
        assign fell_w     = ~sync_q[i] & prev_q[i];
        assign event_d[i] = (rose_w & rise_en[i]) | (fell_w & fall_en[i]);

        always_ff @(posedge clk) begin
            if (rst)
                edge_st[i] <= 1'b0;
            else if (event_d[i])
                edge_st[i] <= 1'b1;
            else if (clr_strobe && clr_bits[i])
                edge_st[i] <= 1'b0;
        end
    end

    assign pin_sync = sync_q;

endmodule

// File: rtl/ic_route.sv
module ic_route
    import ic_pkg::*;
#(
    parameter int NSRC = 9
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] mask,
    input  logic [NSRC-1:0] steer,
    output req_t            req
);
    logic [NSRC-1:0] live;

    always_comb begin
        live     = pend & mask;
        req.fiq  = |(live & steer);
        req.irq  = |(live & ~steer);
        req.wake = |live;
    end

endmodule

// File: rtl/ic_regs.sv
module ic_regs
    import ic_pkg::*;
#(
    parameter int NGPIO = 28,
    parameter int NSRC  = 9,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [3:0]       addr,
    input  logic [DW-1:0]    wdata,
    output logic [NSRC-1:0]  mask_q,
    output logic [NSRC-1:0]  steer_q,
    output logic [NGPIO-1:0] dout_q,
    output logic [NGPIO-1:0] dir_q,
    output logic [NGPIO-1:0] rise_q,
    output logic [NGPIO-1:0] fall_q,
    output logic             clr_strobe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            steer_q <= '0;
            dout_q  <= '0;
            dir_q   <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
        end else begin
            if (hit(we, addr, SEL_MASK))  mask_q  <= wdata[NSRC-1:0];
            if (hit(we, addr, SEL_STEER)) steer_q <= wdata[NSRC-1:0];
            if (hit(we, addr, SEL_DOUT))  dout_q  <= wdata[NGPIO-1:0];
            if (hit(we, addr, SEL_DIR))   dir_q   <= wdata[NGPIO-1:0];
            if (hit(we, addr, SEL_RISE))  rise_q  <= wdata[NGPIO-1:0];
            if (hit(we, addr, SEL_FALL))  fall_q  <= wdata[NGPIO-1:0];
        end
    end

    assign clr_strobe = hit(we, addr, SEL_EDGE);

endmodule

// File: rtl/intc_top.sv
module intc_top
    import ic_pkg::*;
#(
    parameter int NGPIO = 28,
    parameter int NMOD  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [NGPIO-1:0] gpio_in,
    output logic [NGPIO-1:0] gpio_out,
    output logic [NGPIO-1:0] gpio_oe,
    input  logic [NMOD-1:0]  mod_irq,
    output logic             fiq_req,
    output logic             irq_req,
    output logic             wake_req
);
    localparam int NSRC = NMOD + 1;

    logic [NSRC-1:0]  mask_q;
    logic [NSRC-1:0]  steer_q;
    logic [NGPIO-1:0] rise_en;
    logic [NGPIO-1:0] fall_en;
    logic [NGPIO-1:0] pin_sync;
    logic [NGPIO-1:0] edge_st;
    logic [NSRC-1:0]  pend;
    logic             clr_strobe;
    req_t             req;

    ic_regs #(.NGPIO(NGPIO), .NSRC(NSRC), .DW(32)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .mask_q     (mask_q),
        .steer_q    (steer_q),
        .dout_q     (gpio_out),
        .dir_q      (gpio_oe),
        .rise_q     (rise_en),
        .fall_q     (fall_en),
        .clr_strobe (clr_strobe)
    );

    ic_gpio_edge #(.NGPIO(NGPIO)) u_edge (
        .clk        (clk),
        .rst        (rst),
        .pin_async  (gpio_in),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .clr_strobe (clr_strobe),
        .clr_bits   (reg_wdata[NGPIO-1:0]),
        .pin_sync   (pin_sync),
        .edge_st    (edge_st)
    );

    assign pend = {mod_irq, |edge_st};

    ic_route #(.NSRC(NSRC)) u_route (
        .pend  (pend),
        .mask  (mask_q),
        .steer (steer_q),
        .req   (req)
    );

    assign fiq_req  = req.fiq;
    assign irq_req  = req.irq;
    assign wake_req = req.wake;

    always_comb begin
        case (reg_addr)
            SEL_PEND:  reg_rdata = 32'(pend);
            SEL_MASK:  reg_rdata = 32'(mask_q);
            SEL_STEER: reg_rdata = 32'(steer_q);
            SEL_PIN:   reg_rdata = 32'(pin_sync);
            SEL_DOUT:  reg_rdata = 32'(gpio_out);
            SEL_DIR:   reg_rdata = 32'(gpio_oe);
            SEL_RISE:  reg_rdata = 32'(rise_en);
            SEL_FALL:  reg_rdata = 32'(fall_en);
            SEL_EDGE:  reg_rdata = 32'(edge_st);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int NGPIO = 28,
    parameter int NSRC  = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [3:0]       reg_addr,
    input logic             fiq_req,
    input logic             irq_req,
    input logic             wake_req,
    input logic [NSRC-1:0]  mask_q,
    input logic [NSRC-1:0]  steer_q,
    input logic [NGPIO-1:0] edge_st,
    input logic [NGPIO-1:0] any_en,
    input logic [NSRC-1:0]  pend
);
    // R1
    p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '0 && edge_st == '0 && !fiq_req && !irq_req));

    // R2, R3: newly set status bits must have been armed
    p_armed_only_r2: assert property (@(posedge clk) disable iff (rst)
        ((edge_st & ~$past(edge_st)) & ~$past(any_en)) == '0);

    // R5
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == 4'd8) |=> ((edge_st & $past(edge_st)) == $past(edge_st)));

    // R6
    p_gpio_summary_r6: assert property (@(posedge clk) disable iff (rst)
        (|edge_st) |-> pend[0]);

    // R8
    p_fiq_needs_mask_r8: assert property (@(posedge clk) disable iff (rst)
        fiq_req |-> (|(mask_q & steer_q)));

    // R9
    p_wake_cover_r9: assert property (@(posedge clk) disable iff (rst)
        (fiq_req || irq_req) |-> wake_req);

endmodule

bind intc_top intc_checker #(.NGPIO(NGPIO), .NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .fiq_req  (fiq_req),
    .irq_req  (irq_req),
    .wake_req (wake_req),
    .mask_q   (mask_q),
    .steer_q  (steer_q),
    .edge_st  (edge_st),
    .any_en   (rise_en | fall_en),
    .pend     (pend)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;
    localparam int NGPIO = 28;
    localparam int NMOD  = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_we = 1'b0;
    logic [3:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [NGPIO-1:0] gpio_in = '0;
    logic [NGPIO-1:0] gpio_out;
    logic [NGPIO-1:0] gpio_oe;
    logic [NMOD-1:0]  mod_irq = '0;
    logic             fiq_req;
    logic             irq_req;
    logic             wake_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    intc_top #(.NGPIO(NGPIO), .NMOD(NMOD)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_in(gpio_in),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .mod_irq(mod_irq),
        .fiq_req(fiq_req), .irq_req(irq_req), .wake_req(wake_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 1; a <= 8; a++) begin
            rd(4'(a), v);
            chk("R1 reg after reset", v, 32'h0);
        end
        chk("R1 outputs after reset", {gpio_out, gpio_oe}, '0);
        chk("R1 requests after reset", {29'd0, fiq_req, irq_req, wake_req}, 32'h0);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(4'd6, 32'h0000_0008);
        gpio_in[3] = 1'b1; gpio_in[5] = 1'b1;
        cyc(2);
        rd(4'd8, v); chk("R11 not yet at edge k+1", v, 32'h0);
        cyc(1);
        rd(4'd8, v); chk("R11/R2 set at edge k+2, pin5 disabled", v, 32'h8);
        gpio_in[3] = 1'b0;
        cyc(4);
        rd(4'd8, v); chk("R2 falling ignored on rise-only pin", v, 32'h8);
        wr(4'd8, 32'h8);
        rd(4'd8, v); chk("R5 clear rise bit", v, 32'h0);
        gpio_in[5] = 1'b0;
        wr(4'd6, 32'h0);
        cyc(3);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        wr(4'd7, 32'h0800_0080);
        gpio_in[7] = 1'b1; gpio_in[27] = 1'b1;
        cyc(4);
        rd(4'd8, v); chk("R3 rising ignored on fall-only pins", v, 32'h0);
        gpio_in[7] = 1'b0; gpio_in[27] = 1'b0;
        cyc(4);
        rd(4'd8, v); chk("R3 falling sets pins 7 and 27", v, 32'h0800_0080);
        rd(4'd0, v); chk("R6 pending bit0 from edge status", v, 32'h1);
        wr(4'd8, 32'h0000_0080);
        rd(4'd8, v); chk("R5 partial clear keeps pin 27", v, 32'h0800_0000);
        wr(4'd8, 32'h0800_0000);
        wr(4'd7, 32'h0);
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr(4'd6, 32'h400); wr(4'd7, 32'h400);
        gpio_in[10] = 1'b1;
        cyc(4);
        rd(4'd8, v); chk("R4 rise on both-edge pin", v, 32'h400);
        wr(4'd8, 32'h400);
        gpio_in[10] = 1'b0;
        cyc(4);
        rd(4'd8, v); chk("R4 fall on both-edge pin", v, 32'h400);
        wr(4'd8, 32'h0);
        rd(4'd8, v); chk("R5 writing zeros keeps status", v, 32'h400);
        wr(4'd8, 32'h400);
        rd(4'd8, v); chk("R5 write-one clears", v, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] v;
        wr(4'd1, 32'h0000_0104);
        wr(4'd2, 32'h0000_0004);
        mod_irq = 8'h82;
        #1;
        rd(4'd0, v); chk("R6 pending mirrors module lines", v, 32'h0000_0104);
        chk("R7 module1 steered fast, module7 normal", {29'd0, fiq_req, irq_req, wake_req}, 32'h7);
        mod_irq = 8'h02; #1;
        chk("R7 only fast source", {29'd0, fiq_req, irq_req, wake_req}, 32'h5);
        wr(4'd2, 32'h0);
        chk("R7 restearing to normal", {29'd0, fiq_req, irq_req, wake_req}, 32'h3);
        wr(4'd1, 32'h0);
        chk("R8 masked source raises nothing", {29'd0, fiq_req, irq_req, wake_req}, 32'h0);
        mod_irq = '0;
    endtask

    task automatic t_gpio_route();
        wr(4'd6, 32'h1); wr(4'd1, 32'h1); wr(4'd2, 32'h1);
        gpio_in[0] = 1'b1;
        cyc(4);
        chk("R9/R7 gpio summary steered fast", {29'd0, fiq_req, irq_req, wake_req}, 32'h5);
        wr(4'd2, 32'h0);
        chk("R9 wake independent of steering", {29'd0, fiq_req, irq_req, wake_req}, 32'h3);
        wr(4'd8, 32'h1);
        chk("R6 cleared status drops requests", {29'd0, fiq_req, irq_req, wake_req}, 32'h0);
        gpio_in[0] = 1'b0;
        wr(4'd6, 32'h0); wr(4'd1, 32'h0);
        cyc(3);
    endtask

    task automatic t_pins();
        logic [31:0] v;
        gpio_in[20] = 1'b1;
        cyc(1);
        rd(4'd3, v); chk("R10 pin not visible after edge k", v, 32'h0);
        cyc(1);
        rd(4'd3, v); chk("R10 pin visible after edge k+1", v, 32'h0010_0000);
        rd(4'd8, v); chk("R2 no capture without enable", v, 32'h0);
        wr(4'd4, 32'h0A5A_5A5A);
        wr(4'd5, 32'h0F00_00F0);
        chk("R10 gpio_out", 32'(gpio_out), 32'h0A5A_5A5A);
        chk("R10 gpio_oe", 32'(gpio_oe), 32'h0F00_00F0);
        rd(4'd4, v); chk("R10 out readback", v, 32'h0A5A_5A5A);
        gpio_in[20] = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_route();
        t_gpio_route();
        t_pins();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule